// File: doc/BRIEF.md
# Bitstream Container Header Parser

This block accepts a programmable-logic configuration file one byte per cycle over a valid/ready stream. It first checks a fixed 13-byte signature. It then walks the tagged sections that follow. Each section is a one-character tag, a big-endian length and that many payload bytes. The block records the lengths of the four metadata sections and whether each one ends in a zero terminator. It also records the length of the configuration section. The configuration section's payload goes out on a byte stream that carries first-byte and last-byte flags.

The configuration payload passes straight through without a register stage, so backpressure on the output holds the input in the same cycle. The final input byte of the file is marked with a last flag. The parse stops in one of two ways. It reaches a clean end, which raises `done`. Or it finds a fault, which latches a non-zero error code. From then on, every further input byte is accepted and discarded until reset.

Top module: `bitfile_parser`

## Requirements
- R1: The first 13 accepted bytes must equal 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01 in that order. The first byte that differs sets `errCode` to 1 (signature mismatch), and nothing is forwarded.
- R2: After the signature, each section is one tag byte, then a big-endian length, then the payload. The length is 4 bytes for tag 'e' (0x65) and 2 bytes for every other tag.
- R3: A tag byte below 'a' (0x61) or above 'e' (0x65) sets `errCode` to 2 (bad tag).
- R4: A section with tag 'a' to 'd' whose length is above 255 sets `errCode` to 3 (oversize) when its last length byte arrives. A length above 255 is legal for tag 'e'.
- R5: A metadata section with tag 'a' to 'd' is skipped by consuming exactly its length in bytes. `metaLen[8k+7:8k]` holds the length of tag 'a'+k. `metaValid[k]` is set only if that section's last payload byte is zero, so a zero-length section leaves it clear. A later section with the same tag overwrites both.
- R6: Each payload byte of an 'e' section appears on `outData` in input order. `outFirst` marks byte 1 and `outLast` marks byte number `bitLen`. `bitLen` holds the 32-bit length, and a zero length forwards nothing.
- R7: While `outValid` is high and `outReady` is low, `inReady` is low and no byte is consumed.
- R8: An accepted byte that carries `inLast` but does not complete the signature, a length field or a payload sets `errCode` to 4 (truncated). A signature, tag or oversize fault found on that same byte takes precedence.
- R9: An accepted `inLast` byte that completes the signature, a length field of zero, or a payload raises `done`, with `errCode` left at 0.
- R10: Once `done` or a non-zero `errCode` is present, `inReady` stays high. Further bytes, with or without `inLast`, then leave `done`, `errCode`, `metaValid`, `metaLen` and `bitLen` unchanged, and `outValid` low.
- R11: After reset, `inReady` is high and `done`, `errCode`, `metaValid`, `bitLen` and `outValid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte present |
| inData | input | 8 | Input byte |
| inLast | input | 1 | Final byte of the file |
| inReady | output | 1 | Input byte accepted this cycle when high with inValid |
| outValid | output | 1 | Configuration payload byte present |
| outData | output | 8 | Configuration payload byte |
| outFirst | output | 1 | First payload byte of the section |
| outLast | output | 1 | Last payload byte of the section |
| outReady | input | 1 | Downstream accepts the byte |
| done | output | 1 | Parse ended cleanly |
| errCode | output | 3 | 0 none, 1 signature, 2 bad tag, 3 oversize, 4 truncated |
| metaValid | output | 4 | Zero-terminated flag per metadata tag, bit k for tag 'a'+k |
| metaLen | output | 32 | Latched metadata lengths, 8 bits per tag |
| bitLen | output | 32 | Latched configuration section length |

## Verification
The assertions watch properties that hold on every cycle. On each cycle they confirm that a stalled output blocks the input, and that `done` and an error never appear together. They also confirm that once the parse has stopped, the error code and the latched results stay fixed and no byte is forwarded. Beyond that, they check that the first-byte flag drops after the first byte is handed over. The bench scenarios are needed for the content checks: the exact signature bytes, the 2-byte versus 4-byte length fields, and the terminator test. They also cover where a truncation is detected and which fault wins on one byte, and they compare the forwarded byte sequence and its flags with a reference walk of each generated file.

// File: rtl/bitfile_pkg.sv
package bitfile_pkg;

  localparam int PRE_LEN = 13;
  localparam int PRE_IDX_W = $clog2(PRE_LEN);

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_PREAMBLE = 3'd1,
    ERR_BADTYPE  = 3'd2,
    ERR_OVERSIZE = 3'd3,
    ERR_TRUNC    = 3'd4
  } errCode_e;

  typedef enum logic [2:0] {
    ST_PRE, ST_TYPE, ST_LEN, ST_PAY, ST_DONE, ST_FAIL
  } parseState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic preStep;    // advance signature index
    logic typeLoad;   // latch tag, arm length field
    logic lenStep;    // shift one length byte in
    logic payLoad;    // length complete: arm payload counter, latch length
    logic payStep;    // one payload byte consumed
    logic metaClose;  // last metadata byte: record terminator test
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic preMatch;
    logic preEnd;
    logic typeOk;
    logic lenEnd;
    logic lenBig;
    logic lenZero;
    logic remOne;
    logic curBits;
  } dpStat_t;

  function automatic logic [7:0] preByte(input logic [PRE_IDX_W-1:0] idx);
    logic [7:0] b;
    if (idx == 0 || idx == 10 || idx == 11) b = 8'h00;
    else if (idx == 1)                      b = 8'h09;
    else if (idx == 12)                     b = 8'h01;
    else if (idx[0] == 1'b0)                b = 8'h0F;
    else                                    b = 8'hF0;
    return b;
  endfunction

endpackage

// File: rtl/bitfile_dp.sv
module bitfile_dp
  import bitfile_pkg::*;
#(
  parameter int          META_CNT     = 4,
  parameter int          META_LEN_MAX = 255,
  parameter int          BIT_LEN_W    = 32,
  parameter logic [7:0]  TAG_BASE     = 8'h61
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic [7:0]                                 inData,
  input  dpCtrl_t                                    ctl,
  output dpStat_t                                    stat,
  output logic                                       firstFlag,
  output logic [META_CNT-1:0]                        metaValid,
  output logic [META_CNT*$clog2(META_LEN_MAX+1)-1:0] metaLenFlat,
  output logic [BIT_LEN_W-1:0]                       bitLen
);
  localparam int         META_LEN_W = $clog2(META_LEN_MAX + 1);
  localparam logic [7:0] BIT_TAG    = 8'(TAG_BASE + META_CNT);
  localparam int         LEN_BYTES  = BIT_LEN_W / 8;
  localparam int         LCNT_W     = $clog2(LEN_BYTES + 1);

  logic [PRE_IDX_W-1:0] preIdx;
  logic [7:0]           typeReg;
  logic [BIT_LEN_W-1:0] lenAcc;
  logic [LCNT_W-1:0]    lenCnt;
  logic [BIT_LEN_W-1:0] remain;
  logic [BIT_LEN_W-1:0] newLen;

  assign newLen = {lenAcc[BIT_LEN_W-9:0], inData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preIdx    <= '0;
      typeReg   <= '0;
      lenAcc    <= '0;
      lenCnt    <= '0;
      remain    <= '0;
      firstFlag <= 1'b0;
      bitLen    <= '0;
    end else begin
      if (ctl.preStep) preIdx <= preIdx + 1'b1;
      if (ctl.typeLoad) begin
        typeReg <= inData;
        lenAcc  <= '0;
        lenCnt  <= (inData == BIT_TAG) ? LCNT_W'(LEN_BYTES) : LCNT_W'(2);
      end
      if (ctl.lenStep) begin
        lenAcc <= newLen;
        lenCnt <= lenCnt - 1'b1;
      end
      if (ctl.payLoad) begin
        remain    <= newLen;
        firstFlag <= 1'b1;
        if (typeReg == BIT_TAG) bitLen <= newLen;
      end
      if (ctl.payStep) begin
        remain    <= remain - 1'b1;
        firstFlag <= 1'b0;
      end
    end
  end

  // one length/valid slot per metadata tag
  for (genvar g = 0; g < META_CNT; g++) begin : g_meta
    localparam logic [7:0] SLOT_TAG = 8'(TAG_BASE + g);
    logic [META_LEN_W-1:0] slotLen;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotLen      <= '0;
        metaValid[g] <= 1'b0;
      end else if (typeReg == SLOT_TAG) begin
        if (ctl.payLoad) begin
          slotLen      <= newLen[META_LEN_W-1:0];
          metaValid[g] <= 1'b0;
        end else if (ctl.metaClose) begin
          metaValid[g] <= (inData == 8'h00);
        end
      end
    end
    assign metaLenFlat[g*META_LEN_W +: META_LEN_W] = slotLen;
  end

  always_comb begin
    stat.preMatch = (inData == preByte(preIdx));
    stat.preEnd   = (preIdx == PRE_IDX_W'(PRE_LEN - 1));
    stat.typeOk   = (inData >= TAG_BASE) && (inData <= BIT_TAG);
    stat.lenEnd   = (lenCnt == LCNT_W'(1));
    stat.curBits  = (typeReg == BIT_TAG);
    stat.lenBig   = !stat.curBits && (newLen > BIT_LEN_W'(META_LEN_MAX));
    stat.lenZero  = (newLen == '0);
    stat.remOne   = (remain == BIT_LEN_W'(1));
  end

endmodule

// File: rtl/bitfile_ctrl.sv
module bitfile_ctrl
  import bitfile_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inLast,
  input  logic    outReady,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    inReady,
  output logic    outValid,
  output logic    done,
  output logic [2:0] errCode
);
  parseState_e st, nextSt;
  errCode_e    errReg, nextErr;
  logic        accept;

  always_comb begin
    inReady  = (st == ST_PAY && stat.curBits) ? outReady : 1'b1;
    outValid = (st == ST_PAY) && stat.curBits && inValid;
  end
  assign accept = inValid && inReady;

  always_comb begin
    ctl     = '0;
    nextSt  = st;
    nextErr = errReg;
    if (accept) begin
      unique case (st)
        ST_PRE: begin
          if (!stat.preMatch) begin
            nextSt = ST_FAIL; nextErr = ERR_PREAMBLE;
          end else begin
            ctl.preStep = 1'b1;
            if (stat.preEnd)  nextSt = inLast ? ST_DONE : ST_TYPE;
            else if (inLast) begin nextSt = ST_FAIL; nextErr = ERR_TRUNC; end
          end
        end
        ST_TYPE: begin
          if (!stat.typeOk) begin
            nextSt = ST_FAIL; nextErr = ERR_BADTYPE;
          end else begin
            ctl.typeLoad = 1'b1;
            if (inLast) begin nextSt = ST_FAIL; nextErr = ERR_TRUNC; end
            else nextSt = ST_LEN;
          end
        end
        ST_LEN: begin
          ctl.lenStep = 1'b1;
          if (stat.lenEnd) begin
            if (stat.lenBig) begin
              nextSt = ST_FAIL; nextErr = ERR_OVERSIZE;
            end else begin
              ctl.payLoad = 1'b1;
              if (stat.lenZero)  nextSt = inLast ? ST_DONE : ST_TYPE;
              else if (inLast) begin nextSt = ST_FAIL; nextErr = ERR_TRUNC; end
              else nextSt = ST_PAY;
            end
          end else if (inLast) begin
            nextSt = ST_FAIL; nextErr = ERR_TRUNC;
          end
        end
        ST_PAY: begin
          ctl.payStep = 1'b1;
          if (stat.remOne) begin
            ctl.metaClose = !stat.curBits;
            nextSt = inLast ? ST_DONE : ST_TYPE;
          end else if (inLast) begin
            nextSt = ST_FAIL; nextErr = ERR_TRUNC;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_PRE;
      errReg <= ERR_NONE;
    end else begin
      st     <= nextSt;
      errReg <= nextErr;
    end
  end

  assign done    = (st == ST_DONE);
  assign errCode = errReg;

endmodule

// File: rtl/bitfile_parser.sv
module bitfile_parser
  import bitfile_pkg::*;
#(
  parameter int         META_CNT     = 4,
  parameter int         META_LEN_MAX = 255,
  parameter int         BIT_LEN_W    = 32,
  parameter logic [7:0] TAG_BASE     = 8'h61
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic                                       inValid,
  input  logic [7:0]                                 inData,
  input  logic                                       inLast,
  output logic                                       inReady,
  output logic                                       outValid,
  output logic [7:0]                                 outData,
  output logic                                       outFirst,
  output logic                                       outLast,
  input  logic                                       outReady,
  output logic                                       done,
  output logic [2:0]                                 errCode,
  output logic [META_CNT-1:0]                        metaValid,
  output logic [META_CNT*$clog2(META_LEN_MAX+1)-1:0] metaLen,
  output logic [BIT_LEN_W-1:0]                       bitLen
);
  dpCtrl_t ctl;
  dpStat_t stat;

  bitfile_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .outReady (outReady),
    .stat     (stat),
    .ctl      (ctl),
    .inReady  (inReady),
    .outValid (outValid),
    .done     (done),
    .errCode  (errCode)
  );

  bitfile_dp #(
    .META_CNT     (META_CNT),
    .META_LEN_MAX (META_LEN_MAX),
    .BIT_LEN_W    (BIT_LEN_W),
    .TAG_BASE     (TAG_BASE)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .inData      (inData),
    .ctl         (ctl),
    .stat        (stat),
    .firstFlag   (outFirst),
    .metaValid   (metaValid),
    .metaLenFlat (metaLen),
    .bitLen      (bitLen)
  );

  assign outData = inData;
  assign outLast = stat.remOne;

endmodule

// File: rtl/bitfile_parser_chk.sv
module bitfile_parser_chk #(
  parameter int META_CNT   = 4,
  parameter int META_LEN_W = 8,
  parameter int BIT_LEN_W  = 32
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           inReady,
  input logic                           outValid,
  input logic                           outReady,
  input logic                           outFirst,
  input logic                           outLast,
  input logic                           done,
  input logic [2:0]                     errCode,
  input logic [META_CNT-1:0]            metaValid,
  input logic [META_CNT*META_LEN_W-1:0] metaLen,
  input logic [BIT_LEN_W-1:0]           bitLen
);
  logic stopped;
  assign stopped = done || (errCode != 3'd0);

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady); // R7

  AST_DONE_NO_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    done |-> errCode == 3'd0); // R9

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errCode != 3'd0 |=> errCode == $past(errCode)); // R10

  AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    stopped |-> !outValid && inReady); // R10

  AST_RESULTS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    stopped |=> $stable(metaValid) && $stable(metaLen) && $stable(bitLen) && $stable(done)); // R10

  AST_FIRST_FLAG_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outFirst && !outLast |=> !outFirst); // R6

endmodule

bind bitfile_parser bitfile_parser_chk #(
  .META_CNT   (META_CNT),
  .META_LEN_W ($clog2(META_LEN_MAX + 1)),
  .BIT_LEN_W  (BIT_LEN_W)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inReady   (inReady),
  .outValid  (outValid),
  .outReady  (outReady),
  .outFirst  (outFirst),
  .outLast   (outLast),
  .done      (done),
  .errCode   (errCode),
  .metaValid (metaValid),
  .metaLen   (metaLen),
  .bitLen    (bitLen)
);

// File: tb/test_bitfile_parser.sv
module test_bitfile_parser;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inLast = 1'b0;
  logic        inReady;
  logic        outValid;
  logic [7:0]  outData;
  logic        outFirst;
  logic        outLast;
  logic        outReady = 1'b1;
  logic        done;
  logic [2:0]  errCode;
  logic [3:0]  metaValid;
  logic [31:0] metaLen;
  logic [31:0] bitLen;

  always #10 clk = ~clk;

  bitfile_parser i_bitfile_parser (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inReady(inReady), .outValid(outValid), .outData(outData), .outFirst(outFirst),
    .outLast(outLast), .outReady(outReady), .done(done), .errCode(errCode),
    .metaValid(metaValid), .metaLen(metaLen), .bitLen(bitLen)
  );

  int checks = 0;
  int fails = 0;
  bit rdyRandom = 0;
  bit gapRandom = 0;
  logic [7:0] fileQ[$];
  logic [9:0] actQ[$];
  logic [9:0] expQ[$];
  logic [2:0]  mErr;
  bit          mDone;
  logic [3:0]  mMetaValid;
  logic [7:0]  mMetaLen [4];
  logic [31:0] mBitLen;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sig(input int k);
    logic [7:0] s [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                           8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
    return s[k];
  endfunction

  // reference walk of the file per the requirements
  function automatic void model(input logic [7:0] q[$]);
    int n, i;
    logic [7:0] t;
    int nl;
    logic [31:0] len;
    n = q.size();
    mErr = 0; mDone = 0; mMetaValid = 0; mBitLen = 0;
    for (int k = 0; k < 4; k++) mMetaLen[k] = 0;
    expQ.delete();
    i = 0;
    for (int k = 0; k < 13; k++) begin
      if (q[i] != sig(k)) begin mErr = 1; return; end
      if (i == n - 1) begin if (k == 12) mDone = 1; else mErr = 4; return; end
      i++;
    end
    forever begin
      t = q[i];
      if (t < 8'h61 || t > 8'h65) begin mErr = 2; return; end
      if (i == n - 1) begin mErr = 4; return; end
      i++;
      nl = (t == 8'h65) ? 4 : 2;
      len = 0;
      for (int j = 0; j < nl; j++) begin
        len = (len << 8) | 32'(q[i]);
        if (j < nl - 1) begin
          if (i == n - 1) begin mErr = 4; return; end
          i++;
        end
      end
      if (t != 8'h65 && len > 255) begin mErr = 3; return; end
      if (t == 8'h65) mBitLen = len;
      else begin mMetaLen[t - 8'h61] = len[7:0]; mMetaValid[t - 8'h61] = 1'b0; end
      if (len == 0) begin
        if (i == n - 1) begin mDone = 1; return; end
        i++;
        continue;
      end
      if (i == n - 1) begin mErr = 4; return; end
      i++;
      for (int p = 0; p < int'(len); p++) begin
        if (t == 8'h65) expQ.push_back({(p == 0), (p == int'(len) - 1), q[i]});
        if (p == int'(len) - 1) begin
          if (t != 8'h65) mMetaValid[t - 8'h61] = (q[i] == 8'h00);
          if (i == n - 1) begin mDone = 1; return; end
          i++;
        end else begin
          if (i == n - 1) begin mErr = 4; return; end
          i++;
        end
      end
    end
  endfunction

  // output capture and stall check, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN && outValid && outReady) actQ.push_back({outFirst, outLast, outData});
    if (rstN && outValid && !outReady)
      chk(inReady == 1'b0, "R7 stall holds input", inReady, 0);
  end

  always @(posedge clk) begin
    #1;
    outReady <= rdyRandom ? ($urandom % 4 != 0) : 1'b1;
  end

  task automatic sendByte(input logic [7:0] b, input bit last);
    if (gapRandom && ($urandom % 4 == 0)) begin
      @(posedge clk); #1;
    end
    inValid = 1'b1; inData = b; inLast = last;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    @(posedge clk); #1;
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; inValid = 1'b0; inLast = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    actQ.delete();
  endtask

  task automatic checkResults(input string tag);
    logic [31:0] expFlat;
    for (int k = 0; k < 4; k++) expFlat[k*8 +: 8] = mMetaLen[k];
    chk(errCode == mErr, {tag, " errCode"}, errCode, mErr);
    chk(done == mDone, {tag, " done"}, done, mDone);
    chk(metaValid == mMetaValid, {tag, " metaValid"}, metaValid, mMetaValid);
    chk(metaLen == expFlat, {tag, " metaLen"}, metaLen, expFlat);
    chk(bitLen == mBitLen, {tag, " bitLen"}, bitLen, mBitLen);
    chk(actQ.size() == expQ.size(), {tag, " stream length"}, actQ.size(), expQ.size());
    if (actQ.size() == expQ.size())
      foreach (expQ[k])
        if (actQ[k] !== expQ[k]) begin
          chk(1'b0, {tag, " stream byte/flags"}, actQ[k], expQ[k]);
          break;
        end
  endtask

  task automatic runFile(input string tag);
    int n;
    n = fileQ.size();
    doReset();
    model(fileQ);
    foreach (fileQ[k]) sendByte(fileQ[k], k == n - 1);
    repeat (3) @(posedge clk);
    #1 checkResults(tag);
    // R10: trailing bytes after the parse stops are ignored
    for (int k = 0; k < 3; k++) sendByte(8'($urandom), 1'($urandom));
    repeat (2) @(posedge clk);
    #1 checkResults({tag, " R10 after stop"});
  endtask

  task automatic addPre();
    for (int k = 0; k < 13; k++) fileQ.push_back(sig(k));
  endtask

  task automatic addSect(input logic [7:0] t, input int len, input bit zt);
    fileQ.push_back(t);
    if (t == 8'h65) begin
      fileQ.push_back(8'(len >> 24)); fileQ.push_back(8'(len >> 16));
    end
    fileQ.push_back(8'(len >> 8)); fileQ.push_back(8'(len));
    for (int p = 0; p < len; p++) begin
      if (t == 8'h65) fileQ.push_back(8'($urandom));
      else if (p == len - 1) fileQ.push_back(zt ? 8'h00 : 8'h41);
      else fileQ.push_back(8'h30 + 8'($urandom % 64));
    end
  endtask

  task automatic fullFile();
    fileQ.delete(); addPre();
    addSect("a", 6, 1); addSect("b", 4, 1); addSect("c", 3, 0);
    addSect("d", 1, 1); addSect("e", 300, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    doReset();
    @(negedge clk);
    chk(inReady == 1'b1, "R11 reset inReady", inReady, 1);
    chk(done == 1'b0 && errCode == 3'd0, "R11 reset done/err", {done, errCode}, 0);
    chk(metaValid == 4'd0 && bitLen == 32'd0, "R11 reset results", metaValid, 0);
    chk(outValid == 1'b0, "R11 reset outValid", outValid, 0);

    fullFile(); runFile("R2 R5 R6 R9 full file");
    rdyRandom = 1; gapRandom = 1;
    fullFile(); runFile("R7 full file backpressure");
    rdyRandom = 0; gapRandom = 0;

    fullFile(); fileQ[5] = 8'h0E; runFile("R1 signature mismatch");
    fileQ.delete(); addPre(); addSect("a", 2, 1); addSect("f", 2, 1); runFile("R3 tag above range");
    fileQ.delete(); addPre(); addSect(8'h60, 2, 1); runFile("R3 tag below range");
    fileQ.delete(); addPre(); addSect("b", 256, 1); runFile("R4 metadata oversize");
    fileQ.delete(); addPre(); addSect("d", 255, 1); addSect("e", 0, 0); runFile("R4 R5 length 255 accepted");
    fileQ.delete(); addPre(); addSect("e", 20, 0);
    repeat (5) void'(fileQ.pop_back());
    runFile("R8 truncated payload");
    fileQ.delete(); addPre(); fileQ.push_back("a"); fileQ.push_back(8'h00); runFile("R8 truncated length");
    fileQ.delete(); addPre(); repeat (6) void'(fileQ.pop_back()); runFile("R8 truncated signature");
    fileQ.delete(); addPre(); fileQ.push_back("c"); fileQ.push_back(8'h01); fileQ.push_back(8'h00);
    runFile("R8 oversize wins over truncation");
    fileQ.delete(); addPre(); fileQ.push_back("z"); runFile("R8 bad tag wins over truncation");
    fileQ.delete(); addPre(); addSect("a", 5, 1); addSect("c", 2, 1); runFile("R9 ends at metadata boundary");
    fileQ.delete(); addPre(); runFile("R9 signature only");
    fileQ.delete(); addPre(); addSect("a", 0, 1); addSect("e", 0, 0); runFile("R5 R6 zero lengths");
    fileQ.delete(); addPre(); addSect("a", 3, 1); addSect("a", 2, 0); addSect("e", 1, 0);
    runFile("R5 R6 repeated tag, one-byte payload");

    for (int r = 0; r < 30; r++) begin
      int ns;
      fileQ.delete(); addPre();
      ns = 1 + $urandom % 5;
      for (int s = 0; s < ns; s++) begin
        logic [7:0] t;
        t = 8'h61 + 8'($urandom % 5);
        addSect(t, (t == 8'h65) ? int'($urandom % 120) : int'($urandom % 40), 1'($urandom));
      end
      if ($urandom % 4 == 0) fileQ[$urandom % fileQ.size()] = 8'($urandom);
      if ($urandom % 4 == 0) begin
        int cut;
        cut = $urandom % fileQ.size();
        repeat (cut) if (fileQ.size() > 1) void'(fileQ.pop_back());
      end
      rdyRandom = 1'($urandom); gapRandom = 1'($urandom);
      runFile("R2 R6 R8 random file");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule